// File: doc/BRIEF.md
# Multi-Polynomial Per-Context CRC Engine

This block speeds up checksum work for a packet processor that runs several hardware threads. Each cycle a thread can hand it one 32-bit data word together with its context number. The engine folds the word into the remainder it holds for that context, using the polynomial recorded for that context. The new remainder comes back on the next cycle. Because every context keeps its own remainder and its own polynomial choice, threads can interleave words freely and a context switch needs no reconfiguration.

Software primes a context by writing a seed value and a mode code. It can read any context's remainder and mode at any time through a combinational read port. A configuration input selects eight contexts or four. With four, the top bit of every context number is ignored, so only contexts 0 to 3 hold state.

Top module: `crc_engine`

## Requirements
- R1: After reset every context remainder is 0, every context mode is CRC-32 (code 0) and `resultValid` is low.
- R2: Mode codes are 0 = CRC-32 (poly 0x04C11DB7, 32 bits), 1 = CRC-32C (0x1EDC6F41, 32 bits), 2 = CRC-16 (0x1021, 16 bits), 3 = CRC-10 (0x233, 10 bits) and 4 = CRC-5 (0x05, 5 bits). Data bits are taken MSB-first, with no reflection and no final inversion. A narrow remainder sits in the low bits of the 32-bit value, and its upper bits are always zero.
- R3: An accepted update raises `resultValid` for exactly one cycle, on the cycle after it is presented. In that cycle `resultRemainder` carries the new remainder, which is also stored for the context.
- R4: `updBytes` values 1 to 4 fold only that many bytes, starting from bit 31 downward. The values 0, 5, 6 and 7 fold all four bytes.
- R5: A write stores `wrSeed` masked to the width of the mode given and records that mode for the context. Mode codes 5 to 7 are stored as code 0.
- R6: A write and an update to the same context in one cycle: the write takes effect, the update is dropped and `resultValid` stays low.
- R7: Contexts that no operation targets keep their state. A write and an update to different contexts in one cycle both take effect.
- R8: With `cfgEightCtx` low, bit 2 of `updCtx`, `wrCtx` and `rdCtx` is ignored. Contexts 4 to 7 are then neither changed nor visible.
- R9: `rdRemainder` and `rdMode` show, in the same cycle, the stored state of the context named by `rdCtx`.
- R10: An update uses the mode stored for its own context, whatever modes the other contexts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEightCtx | input | 1 | 1 = eight contexts, 0 = four contexts |
| updValid | input | 1 | Update request |
| updCtx | input | 3 | Context of the update |
| updBytes | input | 3 | Number of leading bytes to fold |
| updData | input | 32 | Data word |
| wrValid | input | 1 | Seed write request |
| wrCtx | input | 3 | Context of the write |
| wrMode | input | 3 | Mode code stored with the seed |
| wrSeed | input | 32 | Seed value |
| rdCtx | input | 3 | Context to read |
| rdRemainder | output | 32 | Stored remainder of `rdCtx` |
| rdMode | output | 3 | Stored mode of `rdCtx` |
| resultValid | output | 1 | Update result strobe |
| resultRemainder | output | 32 | Remainder after the last update |

## Verification
The hardest case to reach from the ports is one where several contexts hold different polynomials and half-finished remainders, and words for them arrive interleaved. That is the only way a context could pick up another context's mode or remainder. The bench seeds all eight contexts with mixed modes, then runs rounds of round-robin updates with varying byte counts while a reference model tracks every context. It also drives a write and an update in the same cycle, and it switches to four-context mode and back to confirm that the upper contexts were left untouched. The reference result is reached by long division of a 64-bit augmented value, not by bit-serial shifting.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

  localparam int WordW   = 32;
  localparam int MaxCtx  = 8;
  localparam int CtxIdxW = $clog2(MaxCtx);
  localparam int LenW    = 3;
  localparam int ModeW   = 3;

  typedef enum logic [ModeW-1:0] {
    MODE_CRC32  = 3'd0,
    MODE_CRC32C = 3'd1,
    MODE_CRC16  = 3'd2,
    MODE_CRC10  = 3'd3,
    MODE_CRC5   = 3'd4
  } crcMode_e;

  typedef struct packed {
    logic               doUpd;
    logic [CtxIdxW-1:0] updIdx;
    logic [LenW-1:0]    updLen;
    logic               doWr;
    logic [CtxIdxW-1:0] wrIdx;
    crcMode_e           wrMode;
    logic [CtxIdxW-1:0] rdIdx;
  } crcStrobe_t;

  function automatic logic [WordW-1:0] modeMask(input crcMode_e m);
    case (m)
      MODE_CRC16: return 32'h0000_FFFF;
      MODE_CRC10: return 32'h0000_03FF;
      MODE_CRC5:  return 32'h0000_001F;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WordW-1:0] modeTop(input crcMode_e m);
    case (m)
      MODE_CRC16: return 32'h0000_8000;
      MODE_CRC10: return 32'h0000_0200;
      MODE_CRC5:  return 32'h0000_0010;
      default:    return 32'h8000_0000;
    endcase
  endfunction

  function automatic logic [WordW-1:0] modePoly(input crcMode_e m);
    case (m)
      MODE_CRC32C: return 32'h1EDC_6F41;
      MODE_CRC16:  return 32'h0000_1021;
      MODE_CRC10:  return 32'h0000_0233;
      MODE_CRC5:   return 32'h0000_0005;
      default:     return 32'h04C1_1DB7;
    endcase
  endfunction

  // Folds the leading nBytes bytes of data into rem, MSB first.
  function automatic logic [WordW-1:0] crcFold(input logic [WordW-1:0] rem,
                                               input logic [WordW-1:0] data,
                                               input logic [LenW-1:0]  nBytes,
                                               input crcMode_e         m);
    logic [WordW-1:0] r;
    logic fb;
    int nBits;
    nBits = 8 * int'(nBytes);
    r = rem & modeMask(m);
    for (int i = 0; i < WordW; i++) begin
      if (i < nBits) begin
        fb = ((r & modeTop(m)) != '0) ^ data[WordW-1-i];
        r  = (r << 1) & modeMask(m);
        if (fb) r = r ^ modePoly(m);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_engine_ctrl.sv
module crc_engine_ctrl
  import crc_engine_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEightCtx,
  input  logic               updValid,
  input  logic [CtxIdxW-1:0] updCtx,
  input  logic [LenW-1:0]    updBytes,
  input  logic               wrValid,
  input  logic [CtxIdxW-1:0] wrCtx,
  input  logic [ModeW-1:0]   wrMode,
  input  logic [CtxIdxW-1:0] rdCtx,
  output crcStrobe_t         stb
);

  localparam logic [CtxIdxW-1:0] HalfMask = CtxIdxW'(MaxCtx/2 - 1);
  localparam logic [LenW-1:0]    FullLen  = LenW'(WordW/8);

  function automatic logic [CtxIdxW-1:0] foldIdx(input logic [CtxIdxW-1:0] idx,
                                                 input logic eight);
    return eight ? idx : (idx & HalfMask);
  endfunction

  logic [CtxIdxW-1:0] uIdx, wIdx;
  logic               sameCtx;

  assign uIdx    = foldIdx(updCtx, cfgEightCtx);
  assign wIdx    = foldIdx(wrCtx, cfgEightCtx);
  assign sameCtx = (uIdx == wIdx);

  always_comb begin
    stb        = '0;
    stb.doWr   = wrValid;
    stb.wrIdx  = wIdx;
    stb.wrMode = (wrMode <= 3'd4) ? crcMode_e'(wrMode) : MODE_CRC32;
    stb.doUpd  = updValid && !(wrValid && sameCtx);
    stb.updIdx = uIdx;
    stb.updLen = (updBytes >= 3'd1 && updBytes <= FullLen) ? updBytes : FullLen;
    stb.rdIdx  = foldIdx(rdCtx, cfgEightCtx);
  end

  // R8
  half_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEightCtx && updValid) |-> (stb.updIdx[CtxIdxW-1] == 1'b0));

endmodule

// File: rtl/crc_engine_dp.sv
module crc_engine_dp
  import crc_engine_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobe_t         stb,
  input  logic [WordW-1:0]   updData,
  input  logic [WordW-1:0]   wrSeed,
  output logic [WordW-1:0]   rdRemainder,
  output logic [ModeW-1:0]   rdMode,
  output logic               resultValid,
  output logic [WordW-1:0]   resultRemainder
);

  logic [WordW-1:0] ctxRem  [MaxCtx];
  crcMode_e         ctxMode [MaxCtx];
  logic [WordW-1:0] newRem;

  assign newRem = crcFold(ctxRem[stb.updIdx], updData, stb.updLen, ctxMode[stb.updIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MaxCtx; i++) begin
        ctxRem[i]  <= '0;
        ctxMode[i] <= MODE_CRC32;
      end
    end else begin
      for (int i = 0; i < MaxCtx; i++) begin
        if (stb.doWr && stb.wrIdx == CtxIdxW'(i)) begin
          ctxRem[i]  <= wrSeed & modeMask(stb.wrMode);
          ctxMode[i] <= stb.wrMode;
        end else if (stb.doUpd && stb.updIdx == CtxIdxW'(i)) begin
          ctxRem[i]  <= newRem;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid     <= 1'b0;
      resultRemainder <= '0;
    end else begin
      resultValid <= stb.doUpd;
      if (stb.doUpd) resultRemainder <= newRem;
    end
  end

  assign rdRemainder = ctxRem[stb.rdIdx];
  assign rdMode      = ctxMode[stb.rdIdx];

  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWr |=> (ctxRem[$past(stb.wrIdx)] == ($past(wrSeed) & modeMask($past(stb.wrMode)))));

  // R3
  result_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (ctxRem[$past(stb.updIdx)] == resultRemainder || $past(stb.doWr)));

  for (genvar g = 0; g < MaxCtx; g++) begin : gCtxChk
    // R7
    idle_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
      !((stb.doWr && stb.wrIdx == CtxIdxW'(g)) || (stb.doUpd && stb.updIdx == CtxIdxW'(g)))
      |=> $stable(ctxRem[g]));
    // R2
    narrow_width_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((ctxRem[g] & ~modeMask(ctxMode[g])) == '0));
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEightCtx,
  input  logic        updValid,
  input  logic [2:0]  updCtx,
  input  logic [2:0]  updBytes,
  input  logic [31:0] updData,
  input  logic        wrValid,
  input  logic [2:0]  wrCtx,
  input  logic [2:0]  wrMode,
  input  logic [31:0] wrSeed,
  input  logic [2:0]  rdCtx,
  output logic [31:0] rdRemainder,
  output logic [2:0]  rdMode,
  output logic        resultValid,
  output logic [31:0] resultRemainder
);

  crcStrobe_t stb;

  crc_engine_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEightCtx(cfgEightCtx),
    .updValid(updValid), .updCtx(updCtx), .updBytes(updBytes),
    .wrValid(wrValid), .wrCtx(wrCtx), .wrMode(wrMode),
    .rdCtx(rdCtx), .stb(stb)
  );

  crc_engine_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .updData(updData), .wrSeed(wrSeed),
    .rdRemainder(rdRemainder), .rdMode(rdMode),
    .resultValid(resultValid), .resultRemainder(resultRemainder)
  );

  logic portClash;
  assign portClash = wrValid && (cfgEightCtx ? (updCtx == wrCtx) : (updCtx[1:0] == wrCtx[1:0]));

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !portClash) |=> resultValid);

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!updValid || portClash) |=> !resultValid);

endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEightCtx = 1'b1;
  logic        updValid = 1'b0;
  logic [2:0]  updCtx = '0;
  logic [2:0]  updBytes = 3'd4;
  logic [31:0] updData = '0;
  logic        wrValid = 1'b0;
  logic [2:0]  wrCtx = '0;
  logic [2:0]  wrMode = '0;
  logic [31:0] wrSeed = '0;
  logic [2:0]  rdCtx = '0;
  logic [31:0] rdRemainder, resultRemainder;
  logic [2:0]  rdMode;
  logic        resultValid;

  int total = 0;
  int bad = 0;
  logic [31:0] lfsr = 32'hACE1_2468;
  logic [31:0] expRem [8];
  int          expMode [8];

  always #4 clk = ~clk;

  crc_engine u_crc_engine (
    .clk(clk), .rstN(rstN), .cfgEightCtx(cfgEightCtx),
    .updValid(updValid), .updCtx(updCtx), .updBytes(updBytes), .updData(updData),
    .wrValid(wrValid), .wrCtx(wrCtx), .wrMode(wrMode), .wrSeed(wrSeed),
    .rdCtx(rdCtx), .rdRemainder(rdRemainder), .rdMode(rdMode),
    .resultValid(resultValid), .resultRemainder(resultRemainder)
  );

  function automatic logic [31:0] maskOf(input int m);
    case (m)
      2: return 32'hFFFF;
      3: return 32'h3FF;
      4: return 32'h1F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Remainder of (rem * x^k + d * x^w) modulo the full generator.
  function automatic logic [31:0] refCrc(input logic [31:0] rem, input logic [31:0] data,
                                         input int nBytes, input int m);
    int w, k;
    logic [63:0] gen, acc;
    case (m)
      1: begin w = 32; gen = 64'h1_1EDC_6F41; end
      2: begin w = 16; gen = 64'h1_1021; end
      3: begin w = 10; gen = 64'h633; end
      4: begin w = 5;  gen = 64'h25; end
      default: begin w = 32; gen = 64'h1_04C1_1DB7; end
    endcase
    k = (nBytes >= 1 && nBytes <= 4) ? 8 * nBytes : 32;
    acc = ({32'b0, rem & maskOf(m)} << k) ^ (({32'b0, data} >> (32 - k)) << w);
    for (int b = 63; b >= w; b--)
      if (acc[b]) acc = acc ^ (gen << (b - w));
    return acc[31:0];
  endfunction

  function automatic int modeFromCode(input int c);
    return (c <= 4) ? c : 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nextData();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic tick();
    @(negedge clk);
    updValid = 1'b0;
    wrValid  = 1'b0;
  endtask

  task automatic writeCtx(input int c, input int code, input logic [31:0] seed);
    wrValid = 1'b1; wrCtx = 3'(c); wrMode = 3'(code); wrSeed = seed;
    tick();
  endtask

  task automatic updCtxOp(input int c, input int nb, input logic [31:0] d);
    updValid = 1'b1; updCtx = 3'(c); updBytes = 3'(nb); updData = d;
    tick();
  endtask

  task automatic readCtx(input int c, output logic [31:0] r, output logic [2:0] m);
    rdCtx = 3'(c);
    #1;
    r = rdRemainder;
    m = rdMode;
  endtask

  logic [31:0] rr, ex;
  logic [2:0]  rm;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 resultValid", 32'(resultValid), 0);
    for (int c = 0; c < 8; c++) begin
      readCtx(c, rr, rm);
      chk("R1 remainder", rr, 0);
      chk("R1 mode", 32'(rm), 0);
    end

    // R2 R4 known vectors, partial final word
    writeCtx(0, 0, 32'hFFFF_FFFF);
    updCtxOp(0, 4, 32'h3132_3334);
    updCtxOp(0, 4, 32'h3536_3738);
    updCtxOp(0, 1, 32'h39AB_CDEF);
    chk("R2 R4 crc32 vector", resultRemainder, 32'h0376_E6E7);
    writeCtx(2, 2, 32'hFFFF_FFFF);
    updCtxOp(2, 4, 32'h3132_3334);
    updCtxOp(2, 4, 32'h3536_3738);
    updCtxOp(2, 1, 32'h3900_0000);
    chk("R2 R4 crc16 vector", resultRemainder, 32'h0000_29B1);

    // R2 R3 R4 R5 sweep over modes, byte counts, data
    for (int m = 0; m < 5; m++) begin
      for (int nb = 0; nb < 8; nb++) begin
        for (int p = 0; p < 6; p++) begin
          int c;
          c = (m + nb + p) % 8;
          nextData();
          writeCtx(c, m, lfsr);
          ex = refCrc(lfsr & maskOf(m), lfsr ^ 32'h5A5A_0F0F, nb, m);
          updValid = 1'b1; updCtx = 3'(c); updBytes = 3'(nb); updData = lfsr ^ 32'h5A5A_0F0F;
          tick();
          chk("R3 resultValid", 32'(resultValid), 1);
          chk("R2 R4 result", resultRemainder, ex);
          readCtx(c, rr, rm);
          chk("R3 R9 stored", rr, ex);
          @(negedge clk);
          chk("R3 single pulse", 32'(resultValid), 0);
        end
      end
    end

    // R5 mode codes 5..7 and seed masking
    for (int code = 5; code < 8; code++) begin
      writeCtx(1, code, 32'hDEAD_BEEF);
      readCtx(1, rr, rm);
      chk("R5 fallback mode", 32'(rm), 0);
      chk("R5 fallback seed", rr, 32'hDEAD_BEEF);
    end
    writeCtx(4, 4, 32'hFFFF_FFFF);
    readCtx(4, rr, rm);
    chk("R5 crc5 mask", rr, 32'h1F);
    chk("R5 crc5 mode", 32'(rm), 4);

    // R7 R10 interleaved contexts with mixed modes
    for (int c = 0; c < 8; c++) begin
      nextData();
      expMode[c] = (c * 3) % 5;
      expRem[c]  = lfsr & maskOf(expMode[c]);
      writeCtx(c, expMode[c], lfsr);
    end
    for (int round = 0; round < 4; round++) begin
      for (int c = 0; c < 8; c++) begin
        int nb;
        nb = 1 + ((c + round) % 4);
        nextData();
        expRem[c] = refCrc(expRem[c], lfsr, nb, expMode[c]);
        updCtxOp(c, nb, lfsr);
        chk("R10 interleaved result", resultRemainder, expRem[c]);
      end
    end
    for (int c = 0; c < 8; c++) begin
      readCtx(c, rr, rm);
      chk("R7 context kept", rr, expRem[c]);
      chk("R10 context mode", 32'(rm), 32'(expMode[c]));
    end

    // R6 write and update on same context
    wrValid = 1'b1; wrCtx = 3'd3; wrMode = 3'd1; wrSeed = 32'h1234_5678;
    updValid = 1'b1; updCtx = 3'd3; updBytes = 3'd4; updData = 32'hFFFF_0000;
    tick();
    chk("R6 no result", 32'(resultValid), 0);
    readCtx(3, rr, rm);
    chk("R6 seed wins", rr, 32'h1234_5678);
    expRem[3] = 32'h1234_5678; expMode[3] = 1;

    // R7 write and update on different contexts
    ex = refCrc(expRem[2], 32'h0BAD_F00D, 4, expMode[2]);
    wrValid = 1'b1; wrCtx = 3'd1; wrMode = 3'd3; wrSeed = 32'hFFFF_FFFF;
    updValid = 1'b1; updCtx = 3'd2; updBytes = 3'd4; updData = 32'h0BAD_F00D;
    tick();
    chk("R7 parallel result", resultRemainder, ex);
    readCtx(1, rr, rm);
    chk("R7 parallel write", rr, 32'h3FF);
    expRem[2] = ex; expRem[1] = 32'h3FF; expMode[1] = 3;

    // R8 four-context configuration
    cfgEightCtx = 1'b0;
    writeCtx(6, 2, 32'hCAFE_BABE);
    readCtx(2, rr, rm);
    chk("R8 alias write", rr, 32'hBABE);
    readCtx(6, rr, rm);
    chk("R8 alias read", rr, 32'hBABE);
    expRem[2] = 32'hBABE; expMode[2] = 2;
    ex = refCrc(expRem[3], 32'h7777_1111, 2, expMode[3]);
    updCtxOp(7, 2, 32'h7777_1111);
    chk("R8 alias update", resultRemainder, ex);
    expRem[3] = ex;
    cfgEightCtx = 1'b1;
    for (int c = 0; c < 8; c++) begin
      readCtx(c, rr, rm);
      chk("R8 upper untouched", rr, expRem[c]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule